// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block connects a single-word host port to a dynamic memory whose row and column addresses share one set of address pins. A host request carries a full word address. The controller puts the upper bits (the row) on the pins and lowers the active-low row strobe. It then puts the lower bits (the column) on the same pins and lowers the active-low column strobe. A write drives the data and the active-low write enable. A read captures the word the memory returns. Both strobes then rise, and the row strobe stays high for a programmable precharge time before the next access.

Charge in the memory cells leaks away, so an internal interval counter raises a refresh request at a fixed period. A refresh is a row-strobe-only cycle. It opens one row, which makes the memory read that row and restore it, and then closes the row. The refreshed row comes from a counter that steps by one on each refresh and wraps after the last row. A refresh never breaks into a host cycle. Once the running host cycle ends, a waiting refresh is served ahead of any host request that has been accepted but not yet started. The host sees a single ready signal, which is low while any access or refresh is in progress.

Top module: `dram_ctl`

## Requirements
- R1: After reset, `host_ready` is 1, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `host_rvalid` is 0.
- R2: At the cycle where `dram_ras_n` falls for a host access, `dram_addr` holds host address bits [ADDR_W-1:COL_W] (the row). At the cycle where `dram_cas_n` falls, `dram_addr` holds bits [COL_W-1:0] (the column).
- R3: `dram_cas_n` is low only while `dram_ras_n` is low, and `dram_ras_n` falls only while `dram_cas_n` is high.
- R4: A request with `host_we`=1 drives `dram_we_n` low and `dram_wdata` equal to `host_wdata` while `dram_cas_n` is low. A request with `host_we`=0 keeps `dram_we_n` high. A later read of the same address returns the last value written there.
- R5: A request is taken at a rising edge where `host_req` and `host_ready` are both 1. `host_ready` is 0 from the next cycle until the controller is idle again, and it is 0 in every cycle where either strobe is low.
- R6: Between two falling edges of `dram_ras_n`, the row strobe stays high for at least PRECHARGE+1 clock cycles.
- R7: Every REF_INTERVAL cycles a refresh becomes pending. The request stays pending until it is served. It is served as a cycle in which `dram_ras_n` falls and rises while `dram_cas_n` stays high, with the refresh row on `dram_addr`.
- R8: Each refresh uses the row one above the previous refresh row, and the row after NUM_ROWS-1 is 0.
- R9: A pending refresh waits for the running host cycle to end. It then goes ahead of a host request that has been accepted but not yet started. Under continuous host traffic, refreshes still occur at the interval rate, so no row goes unrefreshed for longer than NUM_ROWS refresh periods plus a small slack.
- R10: `host_rvalid` is 1 for exactly one cycle for each read, with `host_rdata` holding the word read. It stays 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | High when idle and able to take a request |
| host_rdata | output | DATA_W | Last word read |
| host_rvalid | output | 1 | One-cycle pulse when `host_rdata` is new |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_wdata | output | DATA_W | Data to memory |
| dram_rdata | input | DATA_W | Data from memory |

## Verification
The bench targets several corner cases, and each one exposes a specific fault:

- **Address split.** It writes and reads the extreme addresses and neighbours that share a row. A swapped or misplaced row/column split lands data in the wrong cell and the read-back differs.
- **Refresh row counter.** It follows every row-strobe-only cycle and checks the step and the wrap from the last row to zero. A counter that skips, stalls or wraps late breaks the sequence.
- **Refresh priority.** It places a request on the edge where a refresh turns pending, and expects the refresh to come before that access. A controller that lets the host go first, or drops the pending flag, fails this test.
- **Refresh under load.** A long stream of back-to-back requests runs against a memory model that marks rows whose charge has aged out. A refresh that is starved by host traffic shows up as an expired row.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARB,
    ST_ROW_STROBE,
    ST_COL_ADDR,
    ST_COL_STROBE,
    ST_FINISH,
    ST_REF_OPEN,
    ST_REF_CLOSE,
    ST_PRECHARGE
  } seq_state_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 40,
  parameter int NUM_ROWS = 16,
  parameter int ROW_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             tick;

  assign tick = (tick_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
    end else if (tick) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // a new tick wins over a completion in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pending <= 1'b0;
    end else if (tick) begin
      ref_pending <= 1'b1;
    end else if (ref_done) begin
      ref_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + 1'b1;
    end
  end

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_pending && !ref_done) |=> ref_pending)
    else $error("refresh request lost before service");

  // R8
  row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_done && ref_row == ROW_LAST) |=> (ref_row == '0))
    else $error("refresh row did not wrap to zero");

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_done |=> $stable(ref_row))
    else $error("refresh row moved without a refresh");

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 8,
  parameter int PRECHARGE = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_req,
  input  logic                    host_we,
  input  logic [ROW_W+COL_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic                    host_ready,
  output logic [DATA_W-1:0]       host_rdata,
  output logic                    host_rvalid,
  input  logic                    ref_pending,
  input  logic [ROW_W-1:0]        ref_row,
  output logic                    ref_done,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]       dram_wdata,
  input  logic [DATA_W-1:0]       dram_rdata
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int PRE_W  = $clog2(PRECHARGE + 1);
  localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(PRECHARGE - 1);

  seq_state_e        state;
  logic              held;
  logic              h_we;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic [PRE_W-1:0]  pre_cnt;
  logic [PIN_W-1:0]  row_part;
  logic [PIN_W-1:0]  col_part;

  assign row_part = PIN_W'(h_addr[ADDR_W-1 -: ROW_W]);
  assign col_part = PIN_W'(h_addr[COL_W-1:0]);
  assign ref_done = (state == ST_REF_CLOSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      host_ready  <= 1'b1;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_addr   <= '0;
      dram_wdata  <= '0;
      held        <= 1'b0;
      h_we        <= 1'b0;
      h_addr      <= '0;
      h_wdata     <= '0;
      pre_cnt     <= '0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            held       <= 1'b1;
            h_we       <= host_we;
            h_addr     <= host_addr;
            h_wdata    <= host_wdata;
            host_ready <= 1'b0;
            state      <= ST_ARB;
          end else if (ref_pending) begin
            host_ready <= 1'b0;
            state      <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (ref_pending) begin
            dram_addr <= PIN_W'(ref_row);
            state     <= ST_REF_OPEN;
          end else if (held) begin
            dram_addr <= row_part;
            state     <= ST_ROW_STROBE;
          end else begin
            host_ready <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_ROW_STROBE: begin
          dram_ras_n <= 1'b0;
          state      <= ST_COL_ADDR;
        end
        ST_COL_ADDR: begin
          dram_addr <= col_part;
          state     <= ST_COL_STROBE;
        end
        ST_COL_STROBE: begin
          dram_cas_n <= 1'b0;
          dram_we_n  <= ~h_we;
          dram_wdata <= h_wdata;
          state      <= ST_FINISH;
        end
        ST_FINISH: begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          if (!h_we) begin
            host_rdata  <= dram_rdata;
            host_rvalid <= 1'b1;
          end
          held    <= 1'b0;
          pre_cnt <= PRE_LOAD;
          state   <= ST_PRECHARGE;
        end
        ST_REF_OPEN: begin
          dram_ras_n <= 1'b0;
          state      <= ST_REF_CLOSE;
        end
        ST_REF_CLOSE: begin
          dram_ras_n <= 1'b1;
          pre_cnt    <= PRE_LOAD;
          state      <= ST_PRECHARGE;
        end
        ST_PRECHARGE: begin
          if (pre_cnt == '0) begin
            if (held || ref_pending) begin
              state <= ST_ARB;
            end else begin
              host_ready <= 1'b1;
              state      <= ST_IDLE;
            end
          end else begin
            pre_cnt <= pre_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker state: consecutive sampled cycles with the row strobe high
  localparam int HC_W = $clog2(PRECHARGE + 2) + 1;
  localparam logic [HC_W-1:0] HC_MIN = HC_W'(PRECHARGE + 1);
  logic [HC_W-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_cnt <= HC_MIN;
    end else if (!dram_ras_n) begin
      high_cnt <= '0;
    end else if (high_cnt < HC_MIN) begin
      high_cnt <= high_cnt + 1'b1;
    end
  end

  // R3
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n)
    else $error("column strobe active without row strobe");

  // R3
  ras_fall_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> dram_cas_n)
    else $error("row strobe fell with column strobe low");

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n || !dram_cas_n) |-> !host_ready)
    else $error("ready high during a memory cycle");

  // R6
  precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (high_cnt >= HC_MIN))
    else $error("row strobe precharge too short");

  // R10
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid)
    else $error("read valid longer than one cycle");

  // R4
  we_only_in_cas_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> !dram_cas_n)
    else $error("write enable outside a column strobe");

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl #(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 8,
  parameter int NUM_ROWS     = 16,
  parameter int REF_INTERVAL = 40,
  parameter int PRECHARGE    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_req,
  input  logic                   host_we,
  input  logic [ROW_W+COL_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic                   host_ready,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   host_rvalid,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]      dram_wdata,
  input  logic [DATA_W-1:0]      dram_rdata
);

  logic             ref_pending;
  logic             ref_done;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_timer #(
    .INTERVAL (REF_INTERVAL),
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .ref_done    (ref_done),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dram_seq #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .DATA_W    (DATA_W),
    .PRECHARGE (PRECHARGE)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_ready  (host_ready),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_done    (ref_done),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_addr   (dram_addr),
    .dram_wdata  (dram_wdata),
    .dram_rdata  (dram_rdata)
  );

endmodule

// File: tb/dram_ctl_test.sv
module dram_ctl_test;

  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 4;
  localparam int COL_W        = 4;
  localparam int DATA_W       = 8;
  localparam int NUM_ROWS     = 16;
  localparam int REF_INTERVAL = 40;
  localparam int PRECHARGE    = 2;
  localparam int ADDR_W       = ROW_W + COL_W;
  localparam int LEAK_LIMIT   = NUM_ROWS * REF_INTERVAL + 60;
  localparam int NVEC         = 15;
  localparam int STREAM_N     = 40;

  // vector: {we, addr[7:0], wdata[7:0], expected read[7:0]}
  localparam logic [24:0] VECS [NVEC] = '{
    {1'b1, 8'h00, 8'hA5, 8'h00},
    {1'b1, 8'h0F, 8'h3C, 8'h00},
    {1'b1, 8'hF0, 8'hC3, 8'h00},
    {1'b1, 8'hFF, 8'h5A, 8'h00},
    {1'b1, 8'h12, 8'h77, 8'h00},
    {1'b1, 8'h13, 8'h88, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'hA5},
    {1'b0, 8'h0F, 8'h00, 8'h3C},
    {1'b0, 8'hF0, 8'h00, 8'hC3},
    {1'b0, 8'hFF, 8'h00, 8'h5A},
    {1'b0, 8'h12, 8'h00, 8'h77},
    {1'b0, 8'h13, 8'h00, 8'h88},
    {1'b1, 8'h12, 8'hE1, 8'h00},
    {1'b0, 8'h12, 8'h00, 8'hE1},
    {1'b0, 8'h13, 8'h00, 8'h88}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_req = 1'b0;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic              host_ready;
  logic [DATA_W-1:0] host_rdata;
  logic              host_rvalid;
  logic              dram_ras_n;
  logic              dram_cas_n;
  logic              dram_we_n;
  logic [ROW_W-1:0]  dram_addr;
  logic [DATA_W-1:0] dram_wdata;
  logic [DATA_W-1:0] dram_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_ctl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .NUM_ROWS(NUM_ROWS), .REF_INTERVAL(REF_INTERVAL), .PRECHARGE(PRECHARGE)
  ) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory with charge ageing ----------------
  logic [DATA_W-1:0] mem [NUM_ROWS][1<<COL_W];
  int                age [NUM_ROWS];
  logic [ROW_W-1:0]  open_row = '0;
  logic              m_ras_q = 1'b1;
  logic              m_cas_q = 1'b1;
  bit                expired = 1'b0;

  initial begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      age[r] = 0;
      for (int c = 0; c < (1<<COL_W); c++) mem[r][c] = '0;
    end
  end

  assign dram_rdata = mem[open_row][dram_addr];

  always @(posedge clk) begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      age[r] = age[r] + 1;
      if (age[r] > LEAK_LIMIT) expired = 1'b1;
    end
    if (m_ras_q && !dram_ras_n) begin
      open_row = dram_addr;
      age[dram_addr] = 0;
    end
    if (m_cas_q && !dram_cas_n && !dram_we_n) mem[open_row][dram_addr] = dram_wdata;
    m_ras_q = dram_ras_n;
    m_cas_q = dram_cas_n;
  end

  // ---------------- pin monitor ----------------
  logic [ADDR_W-1:0] cur_addr = '0;
  logic              cur_we = 1'b0;
  logic [DATA_W-1:0] cur_wdata = '0;
  logic              p_ras = 1'b1;
  logic              p_cas = 1'b1;
  logic [ROW_W-1:0]  row_at_fall = '0;
  bit                cas_seen = 1'b0;
  int                prev_ref = -1;
  bit                wrap_seen = 1'b0;
  int                ref_count = 0;
  bit                prio_watch = 1'b0;
  bit                prio_first_ref = 1'b0;
  bit                mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_ras && !dram_ras_n) begin
        row_at_fall = dram_addr;
        cas_seen = 1'b0;
        // R5 busy means not ready
        chk(host_ready == 1'b0, "R5 ready low during row strobe", host_ready, 0);
      end
      if (p_cas && !dram_cas_n) begin
        cas_seen = 1'b1;
        // R2 row/column split
        chk(row_at_fall == cur_addr[ADDR_W-1 -: ROW_W], "R2 row on pins", row_at_fall,
            cur_addr[ADDR_W-1 -: ROW_W]);
        chk(dram_addr == cur_addr[COL_W-1:0], "R2 column on pins", dram_addr, cur_addr[COL_W-1:0]);
        // R4 write enable and data
        chk(dram_we_n == !cur_we, "R4 write enable level", dram_we_n, !cur_we);
        if (cur_we) chk(dram_wdata == cur_wdata, "R4 write data", dram_wdata, cur_wdata);
      end
      if (!p_ras && dram_ras_n) begin
        if (prio_watch) begin
          prio_first_ref = !cas_seen;
          prio_watch = 1'b0;
        end
        if (!cas_seen) begin
          ref_count++;
          // R7 / R8 refresh row sequence
          if (prev_ref >= 0) begin
            chk(int'(row_at_fall) == (prev_ref + 1) % NUM_ROWS, "R8 refresh row step",
                row_at_fall, (prev_ref + 1) % NUM_ROWS);
            if (prev_ref == NUM_ROWS - 1) wrap_seen = 1'b1;
          end
          prev_ref = row_at_fall;
        end
      end
    end
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end

  // ---------------- host driver ----------------
  task automatic do_op(input bit we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] exp);
    int guard;
    int rv;
    logic [DATA_W-1:0] got;
    guard = 0;
    while (!host_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    cur_addr = a; cur_we = we; cur_wdata = wd;
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    // R5 ready drops after acceptance
    chk(host_ready == 1'b0, "R5 ready low after accept", host_ready, 0);
    rv = 0; got = '0; guard = 0;
    while (!host_ready && guard < 200) begin
      if (host_rvalid) begin
        rv++;
        got = host_rdata;
      end
      @(negedge clk);
      guard++;
    end
    // R10 read valid pulse count
    chk(rv == (we ? 0 : 1), "R10 read valid pulses", rv, we ? 0 : 1);
    if (!we) chk(got == exp, "R4 read-back data", got, exp);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int stream_start;
    int stream_refs;
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(host_ready == 1'b1, "R1 ready after reset", host_ready, 1);
    chk(dram_ras_n == 1'b1, "R1 ras idle", dram_ras_n, 1);
    chk(dram_cas_n == 1'b1, "R1 cas idle", dram_cas_n, 1);
    chk(dram_we_n == 1'b1, "R1 we idle", dram_we_n, 1);
    chk(host_rvalid == 1'b0, "R1 rvalid low", host_rvalid, 0);
    mon_on = 1'b1;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      do_op(VECS[i][24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0]);
    end

    // R9 continuous host traffic
    stream_start = ref_count;
    cyc = 0;
    fork
      begin
        for (int i = 0; i < STREAM_N; i++)
          do_op(1'b1, 8'((i * 7) % 256), 8'(i ^ 8'h5A), 8'h00);
        for (int i = 0; i < STREAM_N; i++)
          do_op(1'b0, 8'((i * 7) % 256), 8'h00, 8'(i ^ 8'h5A));
      end
      begin
        while (cyc >= 0) begin
          @(negedge clk);
          cyc++;
          if (!host_req && host_ready && cyc > 1 && cyc % 1 == 0) begin end
          if (cyc > 100000) cyc = -1;
        end
      end
    join_any
    disable fork;
    stream_refs = ref_count - stream_start;
    chk(stream_refs >= cyc / REF_INTERVAL - 1, "R9 refresh rate under traffic",
        stream_refs, cyc / REF_INTERVAL - 1);
    chk(wrap_seen == 1'b1, "R8 refresh row wrapped", wrap_seen, 1);

    // R9 pending refresh beats an accepted request
    begin
      int guard;
      guard = 0;
      while (!host_ready) @(negedge clk);
      while (dram_ras_n && guard < 400) begin
        @(negedge clk);
        guard++;
      end
      chk(guard < 400, "R7 idle refresh occurs", guard, 0);
      repeat (REF_INTERVAL - 3) @(negedge clk);
      chk(host_ready == 1'b1, "R9 idle before aligned request", host_ready, 1);
      prio_watch = 1'b1;
      do_op(1'b0, 8'hF0, 8'h00, 8'hC3);
      chk(prio_first_ref == 1'b1, "R9 refresh before queued access", prio_first_ref, 1);
    end

    // R7 no row aged past the refresh window
    chk(expired == 1'b0, "R7 every row refreshed in time", expired, 0);
    summary();
  end

endmodule